// File: doc/BRIEF.md
# Dual-Axis Galvanometer Serial Transmitter

This block feeds a two-axis galvanometer scanner over a synchronous, differential serial link. It has four complementary line pairs: one bit clock, one frame-sync line, and one data line for each axis. The bit clock runs at one quarter of the core clock. Each bit period is two core cycles high followed by two core cycles low. Frames are 20 bit periods long and follow each other with no gap. The sync line is high throughout a frame except during its last bit, which carries parity.

Each frame on a data line has three parts: a fixed three-bit header, then a 16-bit position word sent most significant bit first, then a parity bit. The parity bit makes the number of ones in the whole 20-bit frame even. The host writes position words into one two-entry queue per axis, using a valid/ready handshake, and always writes the X word before its Y word.

In the last core cycle of every frame, the transmitter checks the Y queue. If the Y queue holds a word, both axes take their queue heads for the next frame. If it does not, both axes resend their previous word. An X word written on its own therefore never leaves the block paired with an old Y word. Until the first pair arrives, both axes send the centre position 0x8000.

Internally there is one shared frame sequencer with two state machines. The phase machine has the states PH_HIGH and PH_LOW. It moves from PH_HIGH to PH_LOW, or from PH_LOW back to PH_HIGH, after the half-period counter has run for two cycles. The segment machine has the states SEG_HEAD, SEG_POS and SEG_PAR, and it changes state only at the end of a bit:
- SEG_HEAD moves to SEG_POS after 3 bits.
- SEG_POS moves to SEG_PAR after 16 bits.
- SEG_PAR moves to SEG_HEAD after 1 bit. This transition is the frame boundary.

Each axis serializer loads a complete 20-bit frame at the frame boundary and shifts it one place at every bit end.

Top module: `galvo_xy_tx`

## Requirements
- R1: The bit clock (`bclk_p`) is high for exactly 2 core cycles, then low for exactly 2 core cycles. The first cycle after reset is the first high cycle.
- R2: A frame is 20 bit periods with no gap between frames. `fsync_p` is high for bits 1 to 19 and low for bit 20. Both data lines use the same frame timing.
- R3: Every `_n` pin is always the inverse of its `_p` pin. A logic one is therefore sent as p=1, n=0.
- R4: Each frame, as seen on `xdat_p` and `ydat_p`, starts with the header bits 0, 0, 1 in that order, followed by the 16 position bits from bit 15 down to bit 0.
- R5: The 20th bit is chosen so that the 20 bits of a frame contain an even number of ones.
- R6: The data lines and the sync line change only in a core cycle in which `bclk_p` rises. They are therefore stable at the falling edge of the bit clock.
- R7: After reset, and until the first Y word is accepted, both axes send the word 0x8000.
- R8: In the last core cycle of a frame, a non-empty Y queue causes the Y head to be popped, and the X head to be popped if X holds a word. Those words are sent in the next frame. At most one pair is taken per frame. In every other case, both axes resend the word of the previous frame.
- R9: Writing an X word without a Y word does not change either data line. When the Y word arrives later, it is sent together with the oldest waiting X word.
- R10: Each queue holds two words. The queue's ready output is low while it holds two words. A valid word presented while ready is low is not accepted and never appears on a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| x_valid | input | 1 | X word offered |
| x_ready | output | 1 | X queue can accept a word |
| x_word | input | 16 | X position word |
| y_valid | input | 1 | Y word offered |
| y_ready | output | 1 | Y queue can accept a word |
| y_word | input | 16 | Y position word |
| bclk_p | output | 1 | Bit clock, true side |
| bclk_n | output | 1 | Bit clock, inverted side |
| fsync_p | output | 1 | Frame sync, true side; low on the parity bit |
| fsync_n | output | 1 | Frame sync, inverted side |
| xdat_p | output | 1 | X data, true side |
| xdat_n | output | 1 | X data, inverted side |
| ydat_p | output | 1 | Y data, true side |
| ydat_n | output | 1 | Y data, inverted side |

## Verification
The hardest case to reach from the ports is a frame boundary that finds X words waiting while the Y queue is empty. A second hard case is a boundary that finds both queues full, so that two pairs must leave over two successive frames. The stimulus reaches these states by writing only while a frame is in progress, well before its last cycle. First it writes a lone X word and watches several frames repeat the previous word. Then it fills both queues in a single frame and offers one more X word while ready is low. Every frame is decoded from the pins using the generated clock and sync. Each decoded frame is compared with a model queue of pairs, which the model advances once per frame.

// File: rtl/galvo_pkg.sv
package galvo_pkg;

    // Half of the outgoing bit clock
    typedef enum logic {
        PH_HIGH,
        PH_LOW
    } clk_phase_e;

    // Section of the frame currently on the lines
    typedef enum logic [1:0] {
        SEG_HEAD,
        SEG_POS,
        SEG_PAR
    } frame_seg_e;

    localparam int AXES   = 2;
    localparam int AXIS_X = 0;
    localparam int AXIS_Y = 1;

endpackage

// File: rtl/galvo_word_queue.sv
module galvo_word_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         pop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push, take;

    assign in_ready  = (cnt != FULL_CNT);
    assign out_valid = (cnt != '0);
    assign out_data  = mem[rd_ptr];
    assign push      = in_valid && in_ready;
    assign take      = pop && out_valid;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (take) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, take})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/galvo_frame_seq.sv
module galvo_frame_seq
    import galvo_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int HDR_W    = 3,
    parameter int POS_W    = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic sync,
    output logic bit_end,
    output logic frame_end
);
    localparam int HCW     = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int SEG_MAX = (HDR_W > POS_W) ? HDR_W : POS_W;
    localparam int SCW     = $clog2(SEG_MAX + 1);
    localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_CYC - 1);
    localparam logic [SCW-1:0] HDR_LAST  = SCW'(HDR_W - 1);
    localparam logic [SCW-1:0] POS_LAST  = SCW'(POS_W - 1);

    clk_phase_e     ph_q, ph_d;
    frame_seg_e     seg_q, seg_d;
    logic [HCW-1:0] hc_q, hc_d;
    logic [SCW-1:0] sc_q, sc_d;
    logic           half_done, last_cyc;

    assign half_done = (hc_q == HALF_LAST);
    assign last_cyc  = (ph_q == PH_LOW) && half_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_HIGH;
            hc_q  <= '0;
            seg_q <= SEG_HEAD;
            sc_q  <= '0;
        end else begin
            ph_q  <= ph_d;
            hc_q  <= hc_d;
            seg_q <= seg_d;
            sc_q  <= sc_d;
        end
    end

    // Next state
    always_comb begin
        hc_d  = half_done ? '0 : hc_q + 1'b1;
        ph_d  = ph_q;
        seg_d = seg_q;
        sc_d  = sc_q;
        unique case (ph_q)
            PH_HIGH: if (half_done) ph_d = PH_LOW;
            PH_LOW:  if (half_done) ph_d = PH_HIGH;
            default: ph_d = PH_HIGH;
        endcase
        if (last_cyc) begin
            unique case (seg_q)
                SEG_HEAD: begin
                    if (sc_q == HDR_LAST) begin
                        seg_d = SEG_POS;
                        sc_d  = '0;
                    end else begin
                        sc_d = sc_q + 1'b1;
                    end
                end
                SEG_POS: begin
                    if (sc_q == POS_LAST) begin
                        seg_d = SEG_PAR;
                        sc_d  = '0;
                    end else begin
                        sc_d = sc_q + 1'b1;
                    end
                end
                SEG_PAR: begin
                    seg_d = SEG_HEAD;
                    sc_d  = '0;
                end
                default: begin
                    seg_d = SEG_HEAD;
                    sc_d  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        bclk      = (ph_q == PH_HIGH);
        sync      = (seg_q != SEG_PAR);
        bit_end   = last_cyc;
        frame_end = last_cyc && (seg_q == SEG_PAR);
    end

endmodule

// File: rtl/galvo_axis_ser.sv
module galvo_axis_ser #(
    parameter int               HDR_W     = 3,
    parameter int               POS_W     = 16,
    parameter logic [HDR_W-1:0] HDR_PAT   = HDR_W'(1),
    parameter logic [POS_W-1:0] IDLE_WORD = {1'b1, {(POS_W-1){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_end,
    input  logic             frame_end,
    input  logic             load,
    input  logic [POS_W-1:0] new_word,
    output logic             line
);
    localparam int FW = HDR_W + POS_W + 1;

    function automatic logic [FW-1:0] build_frame(input logic [POS_W-1:0] w);
        logic [FW-1:0] f;
        f    = {HDR_PAT, w, 1'b0};
        f[0] = ^f;
        return f;
    endfunction

    logic [POS_W-1:0] word_q, word_d;
    logic [FW-1:0]    sh_q, sh_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= IDLE_WORD;
            sh_q   <= build_frame(IDLE_WORD);
        end else begin
            word_q <= word_d;
            sh_q   <= sh_d;
        end
    end

    // Next state: a fresh frame at the boundary, a shift at every other bit end
    always_comb begin
        word_d = word_q;
        sh_d   = sh_q;
        if (frame_end) begin
            word_d = load ? new_word : word_q;
            sh_d   = build_frame(word_d);
        end else if (bit_end) begin
            sh_d = {sh_q[FW-2:0], 1'b0};
        end
    end

    // Output
    always_comb begin
        line = sh_q[FW-1];
    end

endmodule

// File: rtl/galvo_xy_tx.sv
module galvo_xy_tx
    import galvo_pkg::*;
#(
    parameter int POS_W    = 16,
    parameter int HDR_W    = 3,
    parameter int HALF_CYC = 2,
    parameter int QDEPTH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_valid,
    output logic             x_ready,
    input  logic [POS_W-1:0] x_word,
    input  logic             y_valid,
    output logic             y_ready,
    input  logic [POS_W-1:0] y_word,
    output logic             bclk_p,
    output logic             bclk_n,
    output logic             fsync_p,
    output logic             fsync_n,
    output logic             xdat_p,
    output logic             xdat_n,
    output logic             ydat_p,
    output logic             ydat_n
);
    localparam logic [HDR_W-1:0] HDR_PAT = HDR_W'(1);
    localparam logic [POS_W-1:0] CENTRE  = {1'b1, {(POS_W-1){1'b0}}};

    logic             bclk, sync, bit_end, frame_end, take_pair;
    logic [AXES-1:0]  w_valid, w_ready, q_valid, ax_load, ax_line;
    logic [POS_W-1:0] w_data [AXES];
    logic [POS_W-1:0] q_data [AXES];

    assign w_valid[AXIS_X] = x_valid;
    assign w_valid[AXIS_Y] = y_valid;
    assign w_data[AXIS_X]  = x_word;
    assign w_data[AXIS_Y]  = y_word;
    assign x_ready         = w_ready[AXIS_X];
    assign y_ready         = w_ready[AXIS_Y];

    galvo_frame_seq #(
        .HALF_CYC (HALF_CYC),
        .HDR_W    (HDR_W),
        .POS_W    (POS_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .sync      (sync),
        .bit_end   (bit_end),
        .frame_end (frame_end)
    );

    // Y is written last, so its presence marks a complete pair
    assign take_pair = frame_end && q_valid[AXIS_Y];

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        assign ax_load[a] = take_pair && q_valid[a];

        galvo_word_queue #(
            .W     (POS_W),
            .DEPTH (QDEPTH)
        ) i_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (w_valid[a]),
            .in_ready  (w_ready[a]),
            .in_data   (w_data[a]),
            .out_valid (q_valid[a]),
            .out_data  (q_data[a]),
            .pop       (ax_load[a])
        );

        galvo_axis_ser #(
            .HDR_W     (HDR_W),
            .POS_W     (POS_W),
            .HDR_PAT   (HDR_PAT),
            .IDLE_WORD (CENTRE)
        ) i_ser (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_end   (bit_end),
            .frame_end (frame_end),
            .load      (ax_load[a]),
            .new_word  (q_data[a]),
            .line      (ax_line[a])
        );
    end

    assign bclk_p  = bclk;
    assign bclk_n  = ~bclk;
    assign fsync_p = sync;
    assign fsync_n = ~sync;
    assign xdat_p  = ax_line[AXIS_X];
    assign xdat_n  = ~ax_line[AXIS_X];
    assign ydat_p  = ax_line[AXIS_Y];
    assign ydat_n  = ~ax_line[AXIS_Y];

endmodule

// File: rtl/galvo_xy_tx_chk.sv
module galvo_xy_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_p,
    input logic bclk_n,
    input logic fsync_p,
    input logic fsync_n,
    input logic xdat_p,
    input logic xdat_n,
    input logic ydat_p,
    input logic ydat_n,
    input logic y_ready
);
    logic warm;

    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    assert_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_n != bclk_p) && (fsync_n != fsync_p) && (xdat_n != xdat_p) && (ydat_n != ydat_p));

    assert_clk_high_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        warm && bclk_p && $past(bclk_p) |=> !bclk_p);

    assert_clk_low_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !bclk_p && $past(!bclk_p) |=> bclk_p);

    assert_clk_high_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $rose(bclk_p) |=> bclk_p);

    assert_clk_low_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $fell(bclk_p) |=> !bclk_p);

    assert_xdata_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$stable(xdat_p) |-> $rose(bclk_p));

    assert_ydata_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$stable(ydat_p) |-> $rose(bclk_p));

    assert_sync_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$stable(fsync_p) |-> $rose(bclk_p));

    assert_pop_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $rose(y_ready) |-> $rose(bclk_p) && fsync_p && $past(!fsync_p));

endmodule

bind galvo_xy_tx galvo_xy_tx_chk i_chk (.*);

// File: tb/test_galvo_xy_tx.sv
module test_galvo_xy_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_valid = 1'b0, y_valid = 1'b0;
    logic [15:0] x_word = '0, y_word = '0;
    logic        x_ready, y_ready;
    logic        bclk_p, bclk_n, fsync_p, fsync_n, xdat_p, xdat_n, ydat_p, ydat_n;

    always #4 clk = ~clk;

    galvo_xy_tx i_galvo_xy_tx (.*);

    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    // monitor state
    logic        mon_on = 1'b0;
    logic        prev_clk = 1'b1, prev_x = 1'b0, prev_y = 1'b0, prev_s = 1'b1;
    int          run = 1;
    int          nb = 0;
    int          frames = 0;
    logic [19:0] fx = '0, fy = '0;
    logic [15:0] cur_x = 16'h8000, cur_y = 16'h8000;
    bit          cur_reset = 1'b1;
    logic [15:0] pend_x[$], pend_y[$], xq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            string tag;
            check({bclk_n, fsync_n, xdat_n, ydat_n} == ~{bclk_p, fsync_p, xdat_p, ydat_p},
                  "R3", "complement pairs", {bclk_n, fsync_n, xdat_n, ydat_n},
                  ~{bclk_p, fsync_p, xdat_p, ydat_p});
            if (bclk_p == prev_clk) begin
                run++;
            end else begin
                check(run == 2, "R1", "bit clock half length", run, 2);
                run = 1;
            end
            if (xdat_p != prev_x || ydat_p != prev_y || fsync_p != prev_s)
                check(bclk_p && !prev_clk, "R6", "line change outside clock rise",
                      {prev_clk, bclk_p}, 2'b01);
            if (!bclk_p && prev_clk) begin
                fx = {fx[18:0], xdat_p};
                fy = {fy[18:0], ydat_p};
                nb++;
                if (!fsync_p) begin
                    tag = (xq.size() > 0) ? "R9" : (cur_reset ? "R7" : "R8");
                    check(nb == 20, "R2", "bits between sync lows", nb, 20);
                    check(fx[19:17] == 3'b001, "R4", "x header", fx[19:17], 3'b001);
                    check(fy[19:17] == 3'b001, "R4", "y header", fy[19:17], 3'b001);
                    check(^fx == 1'b0, "R5", "x parity", fx, 0);
                    check(^fy == 1'b0, "R5", "y parity", fy, 0);
                    check(fx[16:1] == cur_x, tag, "x word", fx[16:1], cur_x);
                    check(fy[16:1] == cur_y, tag, "y word", fy[16:1], cur_y);
                    nb = 0;
                    frames++;
                    if (pend_y.size() > 0) begin
                        cur_x = pend_x.pop_front();
                        cur_y = pend_y.pop_front();
                        cur_reset = 1'b0;
                    end
                end
            end
            prev_clk = bclk_p;
            prev_x   = xdat_p;
            prev_y   = ydat_p;
            prev_s   = fsync_p;
        end
    end

    task automatic put(input bit is_y, input logic [15:0] w);
        @(negedge clk);
        if (is_y) begin
            y_valid = 1'b1;
            y_word  = w;
        end else begin
            x_valid = 1'b1;
            x_word  = w;
        end
        @(negedge clk);
        x_valid = 1'b0;
        y_valid = 1'b0;
    endtask

    task automatic put_x(input logic [15:0] w);
        put(1'b0, w);
        xq.push_back(w);
    endtask

    task automatic put_y(input logic [15:0] w);
        put(1'b1, w);
        pend_x.push_back((xq.size() > 0) ? xq.pop_front() : cur_x);
        pend_y.push_back(w);
    endtask

    task automatic wait_frames(input int n);
        int t;
        t = frames + n;
        while (frames < t) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [15:0] pat_x(input int i);
        if (i < 16)       return 16'h0001 << i;
        else if (i == 16) return 16'h0000;
        else if (i == 17) return 16'hFFFF;
        else              return 16'(i * 40503);
    endfunction

    function automatic logic [15:0] pat_y(input int i);
        return ~pat_x(i) ^ 16'(i * 257);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check(bclk_p == 1'b1, "R1", "clock high in reset", bclk_p, 1);
        check(fsync_p == 1'b1, "R2", "sync high in reset", fsync_p, 1);
        check(xdat_p == 1'b0 && ydat_p == 1'b0, "R4", "first header bit", {xdat_p, ydat_p}, 0);
        check(x_ready && y_ready, "R10", "queues ready in reset", {x_ready, y_ready}, 2'b11);
        rst_n  = 1'b1;
        mon_on <= 1'b1;

        // two idle frames carry the centre word (R7)
        wait_frames(2);

        // lone X word: output keeps repeating (R9)
        put_x(16'h1234);
        check(x_ready == 1'b1, "R10", "x ready with one word", x_ready, 1);
        wait_frames(3);
        put_y(16'hABCD);
        wait_frames(2);

        // fill both queues in one frame, then offer an extra X (R10)
        put_x(16'h0F0F);
        put_y(16'h5A5A);
        put_x(16'hC3C3);
        put_y(16'h7E81);
        check(x_ready == 1'b0 && y_ready == 1'b0, "R10", "ready low when full",
              {x_ready, y_ready}, 0);
        put(1'b0, 16'hDEAD);
        wait_frames(1);
        check(x_ready && y_ready, "R10", "ready back after one pop", {x_ready, y_ready}, 2'b11);
        wait_frames(3);

        // sweep of position patterns, one pair per frame (R4, R5, R8)
        for (int i = 0; i < 40; i++) begin
            put_x(pat_x(i));
            put_y(pat_y(i));
            wait_frames(1);
        end
        wait_frames(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule